// File: doc/BRIEF.md
# Condition code and next-PC unit

This block keeps the processor's three-flag condition code and chooses the program counter for the following instruction. Every cycle it looks at the instruction being executed, the already-incremented PC and a base register value read from the register file. From these it produces the next PC for four kinds of flow: sequential, conditional branch, register jump and subroutine call. For a subroutine call it also asks for the return address to be written into the link register.

The condition code is one-hot: negative, zero or positive. It is loaded from a register-write value whenever the flag-update strobe is high, and it keeps its value otherwise. A conditional branch tests the stored code against a three-bit mask carried in the instruction.

The next-PC path is purely combinational and always uses the stored code. A branch evaluated in the same cycle as a flag update therefore sees the flags from before that update. Memory access, arithmetic and register storage live outside the block. The base register index is passed out so that the register file can supply the base operand.

Top module: `ccnpc_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first update, the condition code output reads 3'b010 (zero).
- R2: When the update strobe is high at a rising clock edge, the condition code becomes 3'b010 if the write value is zero. Otherwise it becomes 3'b100 if the value's most significant bit is 1, and otherwise 3'b001. Exactly one bit is set at all times.
- R3: When the update strobe is low at a rising clock edge, the condition code keeps its value.
- R4: For opcode 4'b0000 (instruction bits [15:12]), the branch is taken when instruction bits [11:9] ANDed with the condition code are nonzero. Bit 11 tests negative, bit 10 tests zero and bit 9 tests positive. A taken branch gives next PC = incremented PC + sign-extended bits [8:0] and raises the redirect output.
- R5: A conditional branch that is not taken, including any branch whose mask is 3'b000, gives next PC = incremented PC with redirect low.
- R6: For opcode 4'b1100, the next PC is the base value and redirect is high. The base select output always equals instruction bits [8:6].
- R7: For opcode 4'b0100, the link write request is high, the link value is the incremented PC and redirect is high. If bit 11 is 1, the next PC is the incremented PC + sign-extended bits [10:0]; if bit 11 is 0, it is the base value.
- R8: For every other opcode, the link write request and redirect are low and the next PC is the incremented PC.
- R9: A branch in the same cycle as a flag update is decided by the condition code held before that update.
- R10: A subroutine call whose base select is 7 (the link register) takes its target from the base value presented in that cycle, which is the link register's old content, not the link value being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction being executed |
| pc_inc_i | input | DW | Incremented program counter |
| base_i | input | DW | Content of the register named by base_sel_o |
| wr_val_i | input | DW | Value being written to the register file |
| cc_upd_i | input | 1 | Load the condition code from wr_val_i |
| cc_o | output | 3 | Condition code {negative, zero, positive} |
| npc_o | output | DW | Next program counter |
| redirect_o | output | 1 | Flow leaves the sequential path |
| link_we_o | output | 1 | Request to write the link register |
| link_val_o | output | DW | Value for the link register |
| base_sel_o | output | 3 | Base register index for the register file |

## Verification
A flag update and a conditional branch can land in the same cycle. The branch must use the old code while the new code shows up one edge later. The bench provokes this with directed cycles that raise the strobe together with a branch whose mask matches only the incoming flag. It also does so at random throughout a long mixed stream. Its reference model holds the flag state and advances it only after each rising edge. So every branch decision is judged against the pre-update code, and the code output is compared on the following cycle.

// File: rtl/ccnpc_pkg.sv
package ccnpc_pkg;

    localparam int unsigned IW = 16;

    localparam logic [3:0] OP_BRC  = 4'h0;
    localparam logic [3:0] OP_CALL = 4'h4;
    localparam logic [3:0] OP_JREG = 4'hC;

    localparam logic [2:0] CC_POS  = 3'b001;
    localparam logic [2:0] CC_ZERO = 3'b010;
    localparam logic [2:0] CC_NEG  = 3'b100;

    typedef struct packed {
        logic [2:0] cc;
    } cc_state_t;

    typedef struct packed {
        logic [15:0] npc;
        logic        redirect;
        logic        link_we;
    } flow_t;

endpackage

// File: rtl/ccnpc_flags.sv
module ccnpc_flags
    import ccnpc_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          upd_i,
    input  logic [DW-1:0] val_i,
    output logic [2:0]    cc_o
);

    cc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_i) begin
            if (val_i == '0) begin
                st_d.cc = CC_ZERO;
            end else if (val_i[DW-1]) begin
                st_d.cc = CC_NEG;
            end else begin
                st_d.cc = CC_POS;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cc: CC_ZERO};
        end else begin
            st_q <= st_d;
        end
    end

    assign cc_o = st_q.cc;

endmodule

// File: rtl/ccnpc_brtest.sv
module ccnpc_brtest (
    input  logic [2:0] mask_i,
    input  logic [2:0] cc_i,
    output logic       take_o
);

    logic [2:0] hit;

    for (genvar g = 0; g < 3; g++) begin : g_lane
        assign hit[g] = mask_i[g] & cc_i[g];
    end

    assign take_o = |hit;

endmodule

// File: rtl/ccnpc_target.sv
module ccnpc_target
    import ccnpc_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic [IW-1:0] instr_i,
    input  logic [DW-1:0] pc_inc_i,
    input  logic [DW-1:0] base_i,
    input  logic          take_i,
    output logic [DW-1:0] npc_o,
    output logic          redirect_o,
    output logic          link_we_o
);

    localparam int unsigned OFS_S = 9;
    localparam int unsigned OFS_L = 11;

    logic [3:0]    opc;
    logic [DW-1:0] rel_s;
    logic [DW-1:0] rel_l;

    assign opc   = instr_i[IW-1 -: 4];
    assign rel_s = {{(DW-OFS_S){instr_i[OFS_S-1]}}, instr_i[OFS_S-1:0]};
    assign rel_l = {{(DW-OFS_L){instr_i[OFS_L-1]}}, instr_i[OFS_L-1:0]};

    always_comb begin
        npc_o      = pc_inc_i;
        redirect_o = 1'b0;
        link_we_o  = 1'b0;
        unique case (opc)
            OP_BRC: begin
                if (take_i) begin
                    npc_o      = pc_inc_i + rel_s;
                    redirect_o = 1'b1;
                end
            end
            OP_JREG: begin
                npc_o      = base_i;
                redirect_o = 1'b1;
            end
            OP_CALL: begin
                link_we_o  = 1'b1;
                redirect_o = 1'b1;
                npc_o      = instr_i[OFS_L] ? (pc_inc_i + rel_l) : base_i;
            end
            default: begin
                npc_o      = pc_inc_i;
            end
        endcase
    end

endmodule

// File: rtl/ccnpc_unit.sv
module ccnpc_unit
    import ccnpc_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [15:0]   instr_i,
    input  logic [DW-1:0] pc_inc_i,
    input  logic [DW-1:0] base_i,
    input  logic [DW-1:0] wr_val_i,
    input  logic          cc_upd_i,
    output logic [2:0]    cc_o,
    output logic [DW-1:0] npc_o,
    output logic          redirect_o,
    output logic          link_we_o,
    output logic [DW-1:0] link_val_o,
    output logic [2:0]    base_sel_o
);

    logic [2:0] cc_q;
    logic       take;

    ccnpc_flags #(.DW(DW)) u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .upd_i  (cc_upd_i),
        .val_i  (wr_val_i),
        .cc_o   (cc_q)
    );

    ccnpc_brtest u_brtest (
        .mask_i (instr_i[11:9]),
        .cc_i   (cc_q),
        .take_o (take)
    );

    ccnpc_target #(.DW(DW)) u_target (
        .instr_i    (instr_i),
        .pc_inc_i   (pc_inc_i),
        .base_i     (base_i),
        .take_i     (take),
        .npc_o      (npc_o),
        .redirect_o (redirect_o),
        .link_we_o  (link_we_o)
    );

    assign cc_o       = cc_q;
    assign link_val_o = pc_inc_i;
    assign base_sel_o = instr_i[8:6];

endmodule

// File: rtl/ccnpc_unit_chk.sv
module ccnpc_unit_chk #(
    parameter int unsigned DW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [15:0]   instr_i,
    input logic [DW-1:0] pc_inc_i,
    input logic [DW-1:0] base_i,
    input logic [DW-1:0] wr_val_i,
    input logic          cc_upd_i,
    input logic [2:0]    cc_o,
    input logic [DW-1:0] npc_o,
    input logic          redirect_o,
    input logic          link_we_o,
    input logic [DW-1:0] link_val_o
);

    // R2
    cc_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(cc_o) == 1);

    // R2
    cc_zero_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cc_upd_i && wr_val_i == '0) |=> (cc_o == 3'b010));

    // R2
    cc_neg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cc_upd_i && wr_val_i[DW-1]) |=> (cc_o == 3'b100));

    // R3
    cc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cc_upd_i |=> $stable(cc_o));

    // R5
    br_empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_i[15:12] == 4'h0 && instr_i[11:9] == 3'b000)
        |-> (!redirect_o && npc_o == pc_inc_i));

    // R6
    jreg_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_i[15:12] == 4'hC) |-> (redirect_o && npc_o == base_i));

    // R7
    link_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_we_o |-> (instr_i[15:12] == 4'h4 && link_val_o == pc_inc_i));

    // R8
    seq_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_i[15:12] != 4'h0 && instr_i[15:12] != 4'h4 && instr_i[15:12] != 4'hC)
        |-> (!redirect_o && !link_we_o && npc_o == pc_inc_i));

endmodule

bind ccnpc_unit ccnpc_unit_chk #(.DW(DW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .instr_i    (instr_i),
    .pc_inc_i   (pc_inc_i),
    .base_i     (base_i),
    .wr_val_i   (wr_val_i),
    .cc_upd_i   (cc_upd_i),
    .cc_o       (cc_o),
    .npc_o      (npc_o),
    .redirect_o (redirect_o),
    .link_we_o  (link_we_o),
    .link_val_o (link_val_o)
);

// File: tb/ccnpc_unit_tb.sv
module ccnpc_unit_tb;

    localparam int unsigned DW = 16;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [15:0]   instr = '0;
    logic [DW-1:0] pc_inc = '0;
    logic [DW-1:0] base = '0;
    logic [DW-1:0] wr_val = '0;
    logic          cc_upd = 1'b0;
    logic [2:0]    cc;
    logic [DW-1:0] npc;
    logic          redirect;
    logic          link_we;
    logic [DW-1:0] link_val;
    logic [2:0]    base_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] m_cc = 3'b010;
    logic       last_upd = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ccnpc_unit #(.DW(DW)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .instr_i    (instr),
        .pc_inc_i   (pc_inc),
        .base_i     (base),
        .wr_val_i   (wr_val),
        .cc_upd_i   (cc_upd),
        .cc_o       (cc),
        .npc_o      (npc),
        .redirect_o (redirect),
        .link_we_o  (link_we),
        .link_val_o (link_val),
        .base_sel_o (base_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] classify(input logic [DW-1:0] v);
        if (v == '0) return 3'b010;
        if (v[DW-1]) return 3'b100;
        return 3'b001;
    endfunction

    // returns {link_we, redirect, npc}
    function automatic logic [DW+1:0] expect_flow(input logic [15:0] ins, input logic [DW-1:0] pc,
                                                  input logic [DW-1:0] b, input logic [2:0] c);
        logic [DW-1:0] r9;
        logic [DW-1:0] r11;
        r9  = {{(DW-9){ins[8]}}, ins[8:0]};
        r11 = {{(DW-11){ins[10]}}, ins[10:0]};
        case (ins[15:12])
            4'h0: begin
                if ((ins[11:9] & c) != 3'b000) return {1'b0, 1'b1, pc + r9};
                return {1'b0, 1'b0, pc};
            end
            4'hC: return {1'b0, 1'b1, b};
            4'h4: return {1'b1, 1'b1, ins[11] ? pc + r11 : b};
            default: return {1'b0, 1'b0, pc};
        endcase
    endfunction

    task automatic cyc(input logic [15:0] ins, input logic [DW-1:0] pc, input logic [DW-1:0] b,
                       input logic [DW-1:0] wv, input logic up);
        logic [DW+1:0] e;
        string t;
        @(negedge clk);
        instr = ins; pc_inc = pc; base = b; wr_val = wv; cc_upd = up;
        #1;
        chk(last_upd ? "R2 flags" : "R3 flags", {29'd0, cc}, {29'd0, m_cc});
        e = expect_flow(ins, pc, b, m_cc);
        case (ins[15:12])
            4'h0: t = e[DW] ? "R4 branch" : "R5 branch";
            4'h4: t = "R7 call";
            4'hC: t = "R6 jump";
            default: t = "R8 sequential";
        endcase
        chk(t, {14'd0, link_we, redirect, npc}, {14'd0, e});
        if (link_we) chk("R7 link value", {16'd0, link_val}, {16'd0, pc});
        chk("R6 base select", {29'd0, base_sel}, {29'd0, ins[8:6]});
        @(posedge clk);
        if (up) m_cc = classify(wv);
        last_upd = up;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset flags", {29'd0, cc}, 32'd2);
        @(negedge clk);
        rst_ni = 1'b1;
        #1;
        chk("R1 flags after release", {29'd0, cc}, 32'd2);

        // R1/R4: zero-mask branch with negative offset from reset state
        cyc(16'h05FE, 16'h3001, 16'h0, 16'h0, 1'b0);
        // R5: empty mask, under each flag
        cyc(16'h0005, 16'h3002, 16'h0, 16'h0, 1'b0);
        // R9: update to N while branching on N: old flag (Z) decides
        @(negedge clk);
        instr = 16'h0810; pc_inc = 16'h4000; base = '0; wr_val = 16'h8000; cc_upd = 1'b1;
        #1;
        chk("R9 branch uses old flags", {31'd0, redirect}, 32'd0);
        chk("R9 pc while update pending", {16'd0, npc}, 32'h4000);
        @(posedge clk);
        m_cc = 3'b100; last_upd = 1'b1;
        cyc(16'h0810, 16'h4000, 16'h0, 16'h0, 1'b0);
        cyc(16'h0005, 16'h4001, 16'h0, 16'h7FFF, 1'b1);
        cyc(16'h0203, 16'h4002, 16'h0, 16'h0000, 1'b1);
        cyc(16'h0005, 16'h4003, 16'h0, 16'h0, 1'b0);
        // R6: register jump
        cyc(16'hC1C0, 16'h3000, 16'h1234, 16'h0, 1'b0);
        // R7: relative call with most negative offset
        cyc(16'h4C00, 16'h3000, 16'h9999, 16'h0, 1'b0);
        // R10: call through base 7 uses presented (old) value
        @(negedge clk);
        instr = 16'h41C0; pc_inc = 16'h3000; base = 16'h5555; cc_upd = 1'b0;
        #1;
        chk("R10 call through link reg", {16'd0, npc}, 32'h5555);
        chk("R10 link value", {15'd0, link_we, link_val}, {15'd0, 1'b1, 16'h3000});
        @(posedge clk);
        last_upd = 1'b0;
        // R8: other opcode
        cyc(16'h1FFF, 16'h2222, 16'hAAAA, 16'h0, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            logic [15:0] ins;
            logic [DW-1:0] wv;
            case ($urandom % 4)
                0: op = 4'h0;
                1: op = 4'h4;
                2: op = 4'hC;
                default: op = 4'($urandom);
            endcase
            ins = {op, 12'($urandom)};
            case ($urandom % 4)
                0: wv = '0;
                1: wv = 16'h8000 | 16'($urandom);
                default: wv = 16'($urandom);
            endcase
            cyc(ins, 16'($urandom), 16'($urandom), wv, 1'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule